// File: doc/BRIEF.md
# Flagged Translation Cache

This block is a small, fully associative cache of page translations for a memory management unit. A lookup brings a virtual address and an access kind (read, write or instruction fetch). The upper part of the address, the virtual page number, is compared against every valid entry at once. On a match, the stored frame number is joined to the untouched low-order byte offset to give the physical address. The outcome is registered and appears one cycle after the request.

Each entry keeps a full set of page status bits beside its page number and frame number: present, read, write and execute permissions, cache-disable, referenced and modified. Every lookup checks the permissions and the present bit against the access kind. A permitted lookup sets the entry's referenced bit, and a permitted write also sets the modified bit. A lookup that finds no entry raises a miss so that an outside agent can walk the page tables and refill the cache. A lookup that finds an entry but may not use it raises a protection fault. Refill writes load entries, and an invalidate-all input empties the cache in one cycle.

Top module: `tlb_flags`

## Requirements
- R1: A lookup on `lk_valid` yields, on the next cycle, `rs_valid`=1. When it hits, `rs_paddr` is the entry's frame number placed above the 12 offset bits, which are copied unchanged from `lk_vaddr[11:0]`. The page number is `lk_vaddr[31:12]`.
- R2: A lookup whose page number matches no valid entry gives `rs_miss`=1, `rs_hit`=0 and `rs_paddr`=0.
- R3: The access kind is encoded 0=read, 1=write, 2=fetch, and 3 is never permitted. `rf_perm` is {read, write, execute} with read in bit 2. A matching entry whose present bit is clear, or whose permission for the kind is clear, gives `rs_prot`=1, `rs_hit`=0 and `rs_paddr`=0, and it changes none of its status bits.
- R4: On a permitted hit the entry's referenced bit is set. `rs_ref` reports its value as it stood before that lookup, so the first hit after a refill shows 0 and later hits show 1.
- R5: On a permitted write hit the entry's modified bit is set. `rs_mod` reports it as it stood before the lookup. Reads and fetches leave it alone.
- R6: On a hit, `rs_nocache` reports the entry's cache-disable bit. `rs_nocache`, `rs_ref` and `rs_mod` are 0 on a miss, on a fault and when no result is valid.
- R7: A refill of a page not already held goes to the lowest-numbered invalid entry. When every entry is valid, it goes to the entry named by a round-robin pointer, which starts at 0 after reset and steps by one, wrapping, each time it picks a victim.
- R8: A refill of a page that is already held overwrites that entry in place, with referenced and modified cleared, and does not move the round-robin pointer.
- R9: `inv_all` clears every entry in one cycle. A refill in the same cycle is dropped.
- R10: A lookup in the same cycle as a refill or an invalidate-all sees the contents from before that edge.
- R11: After reset the cache is empty, `rs_valid` is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| rf_valid | input | 1 | Refill write this cycle |
| rf_vpn | input | 20 | Page number of the refilled translation |
| rf_pfn | input | 20 | Frame number of the refilled translation |
| rf_present | input | 1 | Present bit of the refilled entry |
| rf_perm | input | 3 | Permissions {read, write, execute} |
| rf_nocache | input | 1 | Cache-disable bit of the refilled entry |
| inv_all | input | 1 | Clear all entries |
| rs_valid | output | 1 | A lookup result is presented |
| rs_hit | output | 1 | Permitted translation found |
| rs_miss | output | 1 | No entry holds the page |
| rs_prot | output | 1 | Entry found but access refused |
| rs_paddr | output | 32 | Physical address, 0 unless hit |
| rs_nocache | output | 1 | Cache-disable bit of the hit entry |
| rs_ref | output | 1 | Referenced bit before the lookup |
| rs_mod | output | 1 | Modified bit before the lookup |

## Verification
The two functions that can share a cycle are a lookup and a change of contents, either a refill or an invalidate-all. The bench drives both in the same clock. In one case the looked-up page is the one being refilled, in another it is a page being wiped, and a third pairs invalidate-all with a refill. The same-cycle result must reflect the old contents: a miss for the page being loaded and a hit for the page being cleared. A follow-up lookup one cycle later must show the new contents, and the page refilled alongside the invalidate must be absent.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Access kinds carried on lk_kind
    typedef enum logic [1:0] {
        ACC_RD = 2'd0,
        ACC_WR = 2'd1,
        ACC_EX = 2'd2
    } acc_e;

    // Status bits kept with each cached translation
    typedef struct packed {
        logic present;
        logic can_rd;
        logic can_wr;
        logic can_ex;
        logic nocache;
        logic refd;
        logic dirty;
    } pte_flags_t;

    // Permission check: kind must be granted and page must be resident
    function automatic logic access_allowed(input pte_flags_t f, input logic [1:0] kind);
        logic ok;
        case (kind)
            ACC_RD:  ok = f.can_rd;
            ACC_WR:  ok = f.can_wr;
            ACC_EX:  ok = f.can_ex;
            default: ok = 1'b0;
        endcase
        return ok & f.present;
    endfunction

endpackage

// File: rtl/tlb_cam.sv
// Parallel tag compare: one comparator per entry
module tlb_cam #(
    parameter int N     = 8,
    parameter int KEY_W = 20
) (
    input  logic [KEY_W-1:0]         key,
    input  logic [N-1:0][KEY_W-1:0]  tags,
    input  logic [N-1:0]             vld,
    output logic [N-1:0]             match
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = vld[i] && (tags[i] == key);
    end
endmodule

// File: rtl/tlb_onehot_enc.sv
// Turns a one-hot (or empty) match vector into an index and a found flag
module tlb_onehot_enc #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
        any = |vec;
    end
endmodule

// File: rtl/tlb_victim.sv
// Chooses the refill slot: lowest free entry, else the round-robin pointer
module tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vld,
    input  logic [IDX_W-1:0] rr,
    output logic [IDX_W-1:0] pick,
    output logic             full
);
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx = IDX_W'(i);
            end
        end
        full = &vld;
        pick = full ? rr : free_idx;
    end
endmodule

// File: rtl/tlb_flags.sv
module tlb_flags
    import tlb_pkg::*;
#(
    parameter  int VA_W  = 32,
    parameter  int OFF_W = 12,
    parameter  int PFN_W = 20,
    parameter  int N_ENT = 8,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_kind,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PFN_W-1:0] rf_pfn,
    input  logic             rf_present,
    input  logic [2:0]       rf_perm,
    input  logic             rf_nocache,
    input  logic             inv_all,
    output logic             rs_valid,
    output logic             rs_hit,
    output logic             rs_miss,
    output logic             rs_prot,
    output logic [PA_W-1:0]  rs_paddr,
    output logic             rs_nocache,
    output logic             rs_ref,
    output logic             rs_mod
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENT - 1);

    typedef struct packed {
        logic [N_ENT-1:0]             vld;
        logic [N_ENT-1:0][VPN_W-1:0]  vpn;
        logic [N_ENT-1:0][PFN_W-1:0]  pfn;
        pte_flags_t [N_ENT-1:0]       flg;
        logic [IDX_W-1:0]             rr;
        logic                         r_valid;
        logic                         r_hit;
        logic                         r_miss;
        logic                         r_prot;
        logic                         r_nc;
        logic                         r_ref;
        logic                         r_dirty;
        logic [PA_W-1:0]              r_pa;
    } state_t;

    state_t st_d, st_q;

    // Address split
    logic [VPN_W-1:0] lk_vpn;
    logic [OFF_W-1:0] lk_off;
    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];

    // Lookup compare
    logic [N_ENT-1:0] lk_match;
    logic [IDX_W-1:0] lk_idx;
    logic             lk_any;

    tlb_cam #(.N(N_ENT), .KEY_W(VPN_W)) u_cam_lk (
        .key   (lk_vpn),
        .tags  (st_q.vpn),
        .vld   (st_q.vld),
        .match (lk_match)
    );

    tlb_onehot_enc #(.N(N_ENT), .IDX_W(IDX_W)) u_enc_lk (
        .vec (lk_match),
        .idx (lk_idx),
        .any (lk_any)
    );

    // Refill duplicate detection
    logic [N_ENT-1:0] rf_match;
    logic [IDX_W-1:0] rf_idx;
    logic             rf_any;

    tlb_cam #(.N(N_ENT), .KEY_W(VPN_W)) u_cam_rf (
        .key   (rf_vpn),
        .tags  (st_q.vpn),
        .vld   (st_q.vld),
        .match (rf_match)
    );

    tlb_onehot_enc #(.N(N_ENT), .IDX_W(IDX_W)) u_enc_rf (
        .vec (rf_match),
        .idx (rf_idx),
        .any (rf_any)
    );

    // Victim selection
    logic [IDX_W-1:0] vic_pick;
    logic             vic_full;

    tlb_victim #(.N(N_ENT), .IDX_W(IDX_W)) u_victim (
        .vld  (st_q.vld),
        .rr   (st_q.rr),
        .pick (vic_pick),
        .full (vic_full)
    );

    // Next-state computation
    pte_flags_t       hit_f;
    logic             granted;
    logic [IDX_W-1:0] slot;

    always_comb begin
        st_d    = st_q;
        hit_f   = st_q.flg[lk_idx];
        granted = access_allowed(hit_f, lk_kind);
        slot    = rf_any ? rf_idx : vic_pick;

        // Registered lookup outcome
        st_d.r_valid = lk_valid;
        st_d.r_hit   = lk_valid & lk_any & granted;
        st_d.r_miss  = lk_valid & ~lk_any;
        st_d.r_prot  = lk_valid & lk_any & ~granted;
        st_d.r_pa    = st_d.r_hit ? {st_q.pfn[lk_idx], lk_off} : '0;
        st_d.r_nc    = st_d.r_hit & hit_f.nocache;
        st_d.r_ref   = st_d.r_hit & hit_f.refd;
        st_d.r_dirty = st_d.r_hit & hit_f.dirty;

        // Status update on a permitted access
        if (st_d.r_hit) begin
            st_d.flg[lk_idx].refd = 1'b1;
            if (lk_kind == ACC_WR) begin
                st_d.flg[lk_idx].dirty = 1'b1;
            end
        end

        // Contents change: invalidate dominates refill
        if (inv_all) begin
            st_d.vld = '0;
        end else if (rf_valid) begin
            st_d.vld[slot]          = 1'b1;
            st_d.vpn[slot]          = rf_vpn;
            st_d.pfn[slot]          = rf_pfn;
            st_d.flg[slot].present  = rf_present;
            st_d.flg[slot].can_rd   = rf_perm[2];
            st_d.flg[slot].can_wr   = rf_perm[1];
            st_d.flg[slot].can_ex   = rf_perm[0];
            st_d.flg[slot].nocache  = rf_nocache;
            st_d.flg[slot].refd     = 1'b0;
            st_d.flg[slot].dirty    = 1'b0;
            if (!rf_any && vic_full) begin
                st_d.rr = (st_q.rr == LAST_IDX) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rs_valid   = st_q.r_valid;
    assign rs_hit     = st_q.r_hit;
    assign rs_miss    = st_q.r_miss;
    assign rs_prot    = st_q.r_prot;
    assign rs_paddr   = st_q.r_pa;
    assign rs_nocache = st_q.r_nc;
    assign rs_ref     = st_q.r_ref;
    assign rs_mod     = st_q.r_dirty;

    // Entry valid vector, exposed for the bound checker
    logic [N_ENT-1:0] ent_vld;
    assign ent_vld = st_q.vld;

endmodule

// File: rtl/tlb_flags_chk.sv
module tlb_flags_chk #(
    parameter int OFF_W = 12,
    parameter int PA_W  = 32,
    parameter int N_ENT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [OFF_W-1:0] lk_off,
    input logic             rf_valid,
    input logic             inv_all,
    input logic             rs_valid,
    input logic             rs_hit,
    input logic             rs_miss,
    input logic             rs_prot,
    input logic [PA_W-1:0]  rs_paddr,
    input logic [N_ENT-1:0] ent_vld
);
    // R1: result appears only one cycle after a request
    a_r1_result_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> ($past(lk_valid) && $past(rst_n)));

    // R1: offset passes through untouched
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> (rs_paddr[OFF_W-1:0] == $past(lk_off)));

    // R2: a miss carries no address
    a_r2_miss_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rs_miss |-> (rs_paddr == '0));

    // R3: a fault carries no address, and outcomes are exclusive
    a_r3_prot_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rs_prot |-> (rs_paddr == '0));

    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rs_hit, rs_miss, rs_prot}));

    // R11: outcome flags only with a valid result
    a_r11_outcome_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_hit || rs_miss || rs_prot) |-> rs_valid);

    // R7: an accepted refill leaves at least one valid entry
    a_r7_refill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rf_valid) && !$past(inv_all)) |-> (ent_vld != '0));

    // R9: invalidate-all empties the cache in one cycle
    a_r9_inv_empties: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv_all) |-> (ent_vld == '0));
endmodule

bind tlb_flags tlb_flags_chk #(
    .OFF_W (OFF_W),
    .PA_W  (PA_W),
    .N_ENT (N_ENT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_off   (lk_vaddr[OFF_W-1:0]),
    .rf_valid (rf_valid),
    .inv_all  (inv_all),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_miss  (rs_miss),
    .rs_prot  (rs_prot),
    .rs_paddr (rs_paddr),
    .ent_vld  (ent_vld)
);

// File: tb/sim_tlb_flags.sv
`timescale 1ns/1ps
module sim_tlb_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = '0;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [19:0] rf_pfn = '0;
    logic        rf_present = 1'b0;
    logic [2:0]  rf_perm = '0;
    logic        rf_nocache = 1'b0;
    logic        inv_all = 1'b0;
    logic        rs_valid, rs_hit, rs_miss, rs_prot, rs_nocache, rs_ref, rs_mod;
    logic [31:0] rs_paddr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tlb_flags u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_present(rf_present),
        .rf_perm(rf_perm), .rf_nocache(rf_nocache), .inv_all(inv_all),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_prot(rs_prot),
        .rs_paddr(rs_paddr), .rs_nocache(rs_nocache), .rs_ref(rs_ref), .rs_mod(rs_mod)
    );

    // Outcome codes: 0 hit, 1 miss, 2 protection fault, 3 none
    localparam int NV = 12;
    localparam logic [31:0] V_ADDR [NV] = '{32'h0001_0123, 32'h0001_0FFF, 32'h0001_0004, 32'h0001_1ABC,
                                            32'h0001_1000, 32'h0001_1000, 32'h0002_0010, 32'hFFFF_F800,
                                            32'h0003_0000, 32'hFFFF_F000, 32'hFFFF_F000, 32'h0001_0555};
    localparam logic [1:0]  V_KIND [NV] = '{2'd0, 2'd2, 2'd1, 2'd1, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd1, 2'd0, 2'd3};
    localparam int          V_CODE [NV] = '{0, 0, 2, 0, 0, 2, 2, 0, 1, 2, 0, 2};
    localparam logic [31:0] V_PA   [NV] = '{32'hABCD_E123, 32'hABCD_EFFF, 32'h0, 32'h1234_5ABC,
                                            32'h1234_5000, 32'h0, 32'h0, 32'h0000_1800,
                                            32'h0, 32'h0, 32'h0000_1000, 32'h0};
    // {ref, mod, nocache}
    localparam logic [2:0]  V_FLG  [NV] = '{3'b000, 3'b100, 3'b000, 3'b001, 3'b111, 3'b000,
                                            3'b000, 3'b000, 3'b000, 3'b000, 3'b100, 3'b000};
    localparam string       V_REQ  [NV] = '{"R1", "R4", "R3", "R6", "R5", "R3",
                                            "R3", "R1", "R2", "R3", "R5", "R3"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] pfn, input logic pres,
                          input logic [2:0] perm, input logic nc);
        @(negedge clk);
        rf_valid = 1'b1; rf_vpn = vpn; rf_pfn = pfn; rf_present = pres; rf_perm = perm; rf_nocache = nc;
        @(negedge clk);
        rf_valid = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] kind);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    function automatic int outcome();
        if (!rs_valid) return 3;
        if (rs_hit)    return 0;
        if (rs_miss)   return 1;
        if (rs_prot)   return 2;
        return 3;
    endfunction

    task automatic expect_res(input string req, input int code, input logic [31:0] pa, input logic [2:0] flg);
        check(req, 32'(outcome()), 32'(code));
        check(req, rs_paddr, pa);
        check(req, {29'd0, rs_ref, rs_mod, rs_nocache}, {29'd0, flg});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        @(negedge clk);
        check("R11", {28'd0, rs_valid, rs_hit, rs_miss, rs_prot}, 32'd0);
        check("R11", rs_paddr, 32'd0);
        lookup(32'h0001_0000, 2'd0);
        expect_res("R11", 1, 32'h0, 3'b000);

        // Table contents: perm encoding {read, write, execute}
        refill(20'h00010, 20'hABCDE, 1'b1, 3'b101, 1'b0);
        refill(20'h00011, 20'h12345, 1'b1, 3'b110, 1'b1);
        refill(20'h00020, 20'h00777, 1'b0, 3'b111, 1'b0);
        refill(20'hFFFFF, 20'h00001, 1'b1, 3'b100, 1'b0);

        for (int i = 0; i < NV; i++) begin
            lookup(V_ADDR[i], V_KIND[i]);
            expect_res(V_REQ[i], V_CODE[i], V_PA[i], V_FLG[i]);
        end
        // R11: no lookup, no result
        @(negedge clk);
        check("R11", {31'd0, rs_valid}, 32'd0);

        // R7: fill the remaining entries, then round-robin from entry 0
        for (int i = 0; i < 4; i++) refill(20'h00040 + 20'(i), 20'h00100 + 20'(i), 1'b1, 3'b111, 1'b0);
        refill(20'h00050, 20'h00200, 1'b1, 3'b111, 1'b0);
        lookup(32'h0001_0000, 2'd0);
        expect_res("R7", 1, 32'h0, 3'b000);
        lookup(32'h0005_0ABC, 2'd0);
        expect_res("R7", 0, 32'h0020_0ABC, 3'b000);

        // R8: refill of held page replaces in place, fresh flags, pointer unmoved
        refill(20'hFFFFF, 20'h00002, 1'b1, 3'b111, 1'b0);
        lookup(32'hFFFF_F123, 2'd0);
        expect_res("R8", 0, 32'h0000_2123, 3'b000);
        lookup(32'hFFFF_F000, 2'd1);
        expect_res("R8", 0, 32'h0000_2000, 3'b100);
        refill(20'h00051, 20'h00201, 1'b1, 3'b111, 1'b0);
        lookup(32'h0001_1000, 2'd0);
        expect_res("R8", 1, 32'h0, 3'b000);
        lookup(32'h0002_0000, 2'd0);
        expect_res("R8", 2, 32'h0, 3'b000);
        lookup(32'h0004_0010, 2'd0);
        expect_res("R7", 0, 32'h0010_0010, 3'b000);

        // R10: lookup and refill of the same page in one cycle
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = 32'h0005_2040; lk_kind = 2'd0;
        rf_valid = 1'b1; rf_vpn = 20'h00052; rf_pfn = 20'h00300; rf_present = 1'b1; rf_perm = 3'b100; rf_nocache = 1'b0;
        @(negedge clk);
        lk_valid = 1'b0; rf_valid = 1'b0;
        expect_res("R10", 1, 32'h0, 3'b000);
        lookup(32'h0005_2040, 2'd0);
        expect_res("R10", 0, 32'h0030_0040, 3'b000);

        // R10/R9: lookup with invalidate-all sees old contents
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = 32'h0004_0020; lk_kind = 2'd2; inv_all = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0; inv_all = 1'b0;
        expect_res("R10", 0, 32'h0010_0020, 3'b100);
        lookup(32'h0004_0020, 2'd2);
        expect_res("R9", 1, 32'h0, 3'b000);
        lookup(32'h0005_0000, 2'd0);
        expect_res("R9", 1, 32'h0, 3'b000);

        // R9: refill dropped when paired with invalidate-all
        @(negedge clk);
        inv_all = 1'b1;
        rf_valid = 1'b1; rf_vpn = 20'h00060; rf_pfn = 20'h00400; rf_present = 1'b1; rf_perm = 3'b111; rf_nocache = 1'b0;
        @(negedge clk);
        inv_all = 1'b0; rf_valid = 1'b0;
        lookup(32'h0006_0000, 2'd0);
        expect_res("R9", 1, 32'h0, 3'b000);
        refill(20'h00060, 20'h00400, 1'b1, 3'b111, 1'b1);
        lookup(32'h0006_0FED, 2'd1);
        expect_res("R7", 0, 32'h0040_0FED, 3'b001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R11 watchdog act=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule